// File: doc/BRIEF.md
# Matrix Keypad Row Scanner

This block scans a four-by-four key matrix. It drives four row lines and reads four column lines. A column line is pulled high when no key joins it to a low row. While waiting for a key, the block holds every row low at once. It then only has to notice that any column has gone low. After such a hit, it searches for the key by pulling one row low at a time and reading the columns after each step. Once a key is found and confirmed, it reports a four-bit code together with a one-cycle strobe.

The column lines are asynchronous, so they pass through a two-flop synchronizer first. After every change of the row drive there is a programmable settle wait, which covers line capacitance and the synchronizer latency. A key counts only when the same row and column are seen on a programmable number of consecutive samples. After a report, the block holds all rows low and waits until every column is high before it looks for a new press.

Top module: `keypad_scan`

## Requirements
- R1: While reset is asserted and right after it, all row outputs are 0, the strobe is 0 and the code is 0.
- R2: In the waiting phase all rows are driven 0 together, and any synchronized column at 0 starts a search.
- R3: During a search exactly one row is driven 0. Rows are visited from index 0 upwards. All other rows are driven 1.
- R4: A confirmed key gives the code {row index[1:0], column index[1:0]} with the strobe high for exactly one cycle. The code holds its value until the next report.
- R5: When several columns read 0 on the driven row, the lowest-numbered column is the one reported.
- R6: After every change of the row drive, the columns are not sampled until SETTLE_CYC clock cycles have passed.
- R7: A key is reported only after DEBOUNCE_N consecutive samples that show the same row and column. A bouncing contact gives exactly one report once it becomes stable.
- R8: After a report, all rows are driven 0. No new search starts until all synchronized columns read 1.
- R9: If a search finds no 0 column on any row, the block returns to the waiting phase and gives no report.
- R10: A column change reaches the decision logic through two flip-flops, which is two clock cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cols_i | input | 4 | Column lines, pulled high, 0 where a pressed key meets a low row |
| rows_o | output | 4 | Row drive, 0 pulls the row low |
| code_o | output | 4 | Scan code {row, column} of the last confirmed key |
| valid_o | output | 1 | One-cycle strobe when code_o is updated |

## Verification
On every cycle, the assertions check the shape of the row drive: all rows low, or exactly one row low. They also check that any row change is followed by a settle wait, that each strobe lasts a single cycle, and that the rows are all low whenever a code is issued. A reference model in the bench follows the synchronizer, the settle timer, the debounce count and the search order, and it compares rows, strobe and code every cycle. Some behaviours show only in the bench scenarios: that the lowest column wins, that a glitch too short to confirm fails the search, that a bouncing contact gives one code, and that a held key is not reported twice.

// File: rtl/kp_pkg.sv
package kp_pkg;
   typedef enum logic [1:0] {
      KP_WAIT = 2'd0,
      KP_HUNT = 2'd1,
      KP_HOLD = 2'd2
   } kp_state_e;
endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("kp_sync needs at least two stages");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '1;
         else if (s == 0) chain[s] <= d_i;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/kp_prienc.sv
module kp_prienc #(
   parameter int N  = 4,
   localparam int W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] lines_n_i,
   output logic         any_o,
   output logic [W-1:0] idx_o
);
   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = N-1; i >= 0; i--) begin
         if (!lines_n_i[i]) begin
            any_o = 1'b1;
            idx_o = W'(i);
         end
      end
   end
endmodule

// File: rtl/kp_timer.sv
module kp_timer #(
   parameter int LOAD_VAL = 4,
   localparam int TW = $clog2(LOAD_VAL + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic busy_o
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (load_i)         cnt <= TW'(LOAD_VAL);
      else if (cnt != '0)      cnt <= cnt - 1'b1;
   end

   assign busy_o = (cnt != '0);
endmodule

// File: rtl/keypad_scan.sv
module keypad_scan
   import kp_pkg::*;
#(
   parameter int ROWS        = 4,
   parameter int COLS        = 4,
   parameter int SETTLE_CYC  = 4,
   parameter int DEBOUNCE_N  = 4,
   parameter int SYNC_STAGES = 2,
   localparam int RW     = $clog2(ROWS),
   localparam int CW     = $clog2(COLS),
   localparam int CODE_W = RW + CW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [COLS-1:0]   cols_i,
   output logic [ROWS-1:0]   rows_o,
   output logic [CODE_W-1:0] code_o,
   output logic              valid_o
);
   localparam int HW = $clog2(DEBOUNCE_N + 1);

   if (ROWS < 2 || COLS < 2) begin : g_bad_dims
      $error("keypad_scan needs at least two rows and two columns");
   end
   if (SETTLE_CYC < SYNC_STAGES) begin : g_bad_settle
      $error("SETTLE_CYC must cover the synchronizer latency");
   end
   if (DEBOUNCE_N < 1) begin : g_bad_deb
      $error("DEBOUNCE_N must be at least 1");
   end

   logic [COLS-1:0] cols_s;
   logic            col_any;
   logic [CW-1:0]   col_idx;
   logic            settle_busy;
   logic            load;
   logic            emit;

   kp_state_e       st, st_n;
   logic [RW-1:0]   row, row_n;
   logic [HW-1:0]   hit, hit_n;
   logic [CW-1:0]   cand, cand_n;

   kp_sync #(.WIDTH(COLS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(cols_i), .q_o(cols_s)
   );

   kp_prienc #(.N(COLS)) u_enc (
      .lines_n_i(cols_s), .any_o(col_any), .idx_o(col_idx)
   );

   kp_timer #(.LOAD_VAL(SETTLE_CYC)) u_settle (
      .clk(clk), .rst_n(rst_n), .load_i(load), .busy_o(settle_busy)
   );

   always_comb begin
      st_n   = st;
      row_n  = row;
      hit_n  = hit;
      cand_n = cand;
      load   = 1'b0;
      emit   = 1'b0;
      unique case (st)
         KP_WAIT: begin
            if (!settle_busy && col_any) begin
               st_n  = KP_HUNT;
               row_n = '0;
               hit_n = '0;
               load  = 1'b1;
            end
         end
         KP_HUNT: begin
            if (!settle_busy) begin
               if (col_any) begin
                  if (hit != '0 && cand == col_idx) hit_n = hit + 1'b1;
                  else                              hit_n = HW'(1);
                  cand_n = col_idx;
                  if (hit_n == HW'(DEBOUNCE_N)) begin
                     emit  = 1'b1;
                     st_n  = KP_HOLD;
                     hit_n = '0;
                     load  = 1'b1;
                  end
               end else begin
                  hit_n = '0;
                  load  = 1'b1;
                  if (row == RW'(ROWS-1)) st_n  = KP_WAIT;
                  else                    row_n = row + 1'b1;
               end
            end
         end
         KP_HOLD: begin
            if (!settle_busy && !col_any) st_n = KP_WAIT;
         end
         default: st_n = KP_WAIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= KP_WAIT;
         row     <= '0;
         hit     <= '0;
         cand    <= '0;
         code_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         st      <= st_n;
         row     <= row_n;
         hit     <= hit_n;
         cand    <= cand_n;
         valid_o <= emit;
         if (emit) code_o <= {row, col_idx};
      end
   end

   assign rows_o = (st == KP_HUNT) ? ~(ROWS'(1) << row) : '0;

   // row drive is either all low or a single low row
   assert_row_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rows_o == '0) || ($countones(~rows_o) == 1));

   // every change of the row drive opens a settle window
   assert_settle_after_row_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rows_o) |-> settle_busy);

   // strobe lasts one cycle
   assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // after a report the rows are all low
   assert_rows_low_after_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (rows_o == '0));
endmodule

// File: tb/tb_keypad_scan.sv
module tb_keypad_scan;
   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 4;
   localparam int DEB        = 4;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] cols_i;
   logic [3:0] rows_o;
   logic [3:0] code_o;
   logic       valid_o;
   logic [15:0] keys = '0;   // bit r*4+c = key at row r, column c pressed

   int checks = 0, errors = 0, cyc = 0, pulses = 0;
   int last_code = -1;
   bit done = 0;

   keypad_scan #(.SETTLE_CYC(SETTLE), .DEBOUNCE_N(DEB)) dut (
      .clk(clk), .rst_n(rst_n), .cols_i(cols_i),
      .rows_o(rows_o), .code_o(code_o), .valid_o(valid_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // key matrix with pull-ups
   always_comb begin
      cols_i = 4'hF;
      for (int r = 0; r < 4; r++)
         for (int c = 0; c < 4; c++)
            if (keys[r*4+c] && !rows_o[r]) cols_i[c] = 1'b0;
   end

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // behavioural reference: 0 wait, 1 hunt, 2 hold
   int m_st, m_row, m_hit, m_cand, m_tmr, m_code, m_valid;
   int m_s1, m_s2;

   function automatic int exp_rows();
      return (m_st == 1) ? ((~(1 << m_row)) & 15) : 0;
   endfunction

   always @(negedge clk) begin
      int any, col, ld, emit, nst, nrow, nhit, ncand;
      cyc++;
      if (cyc > WATCHDOG && !done) begin
         check(0, "watchdog", cyc, WATCHDOG);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
      if (!rst_n) begin
         m_st = 0; m_row = 0; m_hit = 0; m_cand = 0; m_tmr = 0;
         m_code = 0; m_valid = 0; m_s1 = 15; m_s2 = 15;
         check(rows_o == 0 && valid_o == 0 && code_o == 0, "R1 reset outputs",
               {rows_o, valid_o, code_o}, 0);
      end else begin
         // per-cycle comparison: R2 R3 R6 R10 (row drive), R4 R5 R7 (code/strobe)
         check(rows_o == exp_rows(), "R2/R3/R6/R10 rows", rows_o, exp_rows());
         check(valid_o == m_valid, "R4/R7 strobe", valid_o, m_valid);
         check(code_o == m_code, "R4/R5 code", code_o, m_code);
         if (valid_o) begin pulses++; last_code = code_o; end
         // advance model by one clock
         any = (m_s2 != 15);
         col = 0;
         for (int i = 3; i >= 0; i--) if (!m_s2[i]) col = i;
         ld = 0; emit = 0; nst = m_st; nrow = m_row; nhit = m_hit; ncand = m_cand;
         if (m_st == 0) begin
            if (m_tmr == 0 && any) begin nst = 1; nrow = 0; nhit = 0; ld = 1; end
         end else if (m_st == 1) begin
            if (m_tmr == 0) begin
               if (any) begin
                  nhit = (m_hit != 0 && m_cand == col) ? m_hit + 1 : 1;
                  ncand = col;
                  if (nhit == DEB) begin emit = 1; nst = 2; nhit = 0; ld = 1; end
               end else begin
                  nhit = 0; ld = 1;
                  if (m_row == 3) nst = 0; else nrow = m_row + 1;
               end
            end
         end else begin
            if (m_tmr == 0 && !any) nst = 0;
         end
         if (emit) m_code = m_row * 4 + col;
         m_valid = emit;
         m_tmr = ld ? SETTLE : (m_tmr > 0 ? m_tmr - 1 : 0);
         m_s2 = m_s1; m_s1 = cols_i;
         m_st = nst; m_row = nrow; m_hit = nhit; m_cand = ncand;
      end
   end

   task automatic press(logic [15:0] k, int hold, int gap);
      @(posedge clk); #1 keys = k;
      repeat (hold) @(posedge clk);
      #1 keys = '0;
      repeat (gap) @(posedge clk);
   endtask

   initial begin
      int p0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (5) @(posedge clk);

      // R4: single key, row 0 column 0
      p0 = pulses; press(16'h0001, 100, 40);
      check(pulses - p0 == 1, "R4 one report", pulses - p0, 1);
      check(last_code == 0, "R4 code r0c0", last_code, 0);

      // R3: key in last row found by the walk, row 3 column 0
      p0 = pulses; press(16'h1000, 100, 40);
      check(last_code == 12, "R3 code r3c0", last_code, 12);

      // R4: row 2 column 3
      p0 = pulses; press(16'h0800, 100, 40);
      check(last_code == 11, "R4 code r2c3", last_code, 11);

      // R5: two columns on row 1, columns 2 and 3 -> column 2
      p0 = pulses; press(16'h00C0, 100, 40);
      check(pulses - p0 == 1, "R5 one report", pulses - p0, 1);
      check(last_code == 6, "R5 lowest column", last_code, 6);

      // R9: glitch too short to survive the settle wait
      p0 = pulses; press(16'h0200, 3, 80);
      check(pulses - p0 == 0, "R9 no report on failed search", pulses - p0, 0);
      check(rows_o == 0, "R9 back to all rows low", rows_o, 0);

      // R8: long hold gives exactly one code, rows stay low meanwhile
      p0 = pulses;
      @(posedge clk); #1 keys = 16'h0020;
      repeat (300) @(posedge clk);
      check(pulses - p0 == 1, "R8 no repeat while held", pulses - p0, 1);
      check(rows_o == 0, "R8 rows low while held", rows_o, 0);
      check(last_code == 5, "R8 code r1c1", last_code, 5);
      #1 keys = '0;
      repeat (40) @(posedge clk);

      // R7: bouncing contact then stable -> exactly one code
      p0 = pulses;
      for (int b = 0; b < 20; b++) begin
         @(posedge clk); #1 keys = 16'h0004;
         @(posedge clk); #1 keys = '0;
      end
      press(16'h0004, 100, 40);
      check(pulses - p0 == 1, "R7 single report after bounce", pulses - p0, 1);
      check(last_code == 2, "R7 code r0c2", last_code, 2);

      // R10/R2: fresh press after release detected again
      p0 = pulses; press(16'h8000, 100, 40);
      check(last_code == 15, "R2 code r3c3", last_code, 15);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule